// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

The block sends bytes in asynchronous frames. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Bit timing comes from a one-cycle tick input that pulses once per bit period, at the bit rate itself and not at an oversampled rate. The block drives an output clock alongside the data. That clock rises with every tick, and the data line changes only at those rising edges.

A processor writes a byte into a holding register. On the first tick at which the shifter is idle or is ending a stop bit, the held byte moves into the shift register, its start bit goes out, and an interrupt is raised to report that the holding register is empty. If software refills the holding register before the running frame ends, the next start bit follows the stop bit with no idle period. The interrupt stays high until the processor acknowledges it or writes a new byte.

Top module: `dbuf_serial_tx`

## Requirements
- R1: While reset is held and right after it, `txd_o` is 1, `bclk_o` is 0 and `irq_o` is 0.
- R2: A frame is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. Each bit is held from one `bit_tick_i` to the next.
- R3: The clock edge that samples `bit_tick_i` high also sets `bclk_o` to 1, and `bclk_o` stays 1 for `HIGH_CYC` cycles. `txd_o` changes only in a cycle where `bclk_o` has just risen, provided ticks are more than `HIGH_CYC` cycles apart.
- R4: A held byte moves to the shifter only on a tick. The shifter must be idle or ending its stop bit at that tick. The start bit appears on `txd_o` from that same tick.
- R5: Every transfer into the shifter sets `irq_o` to 1 from the transfer tick onward.
- R6: `irq_o` clears in the cycle after `irq_ack_i` or `wr_en_i` is high. If a transfer happens in the same cycle, the set takes priority and `irq_o` stays 1.
- R7: A byte written before the current stop bit ends has its start bit sent on the tick that ends that stop bit.
- R8: When no byte is held, `txd_o` stays at 1 after a stop bit and through every later tick.
- R9: A second write before a transfer replaces the held byte. Only the last byte written is sent.
- R10: A write with no tick starts nothing: `txd_o` stays 1 and `irq_o` stays 0 until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| txd_o | output | 1 | Serial data line |
| bclk_o | output | 1 | Output bit clock |
| irq_o | output | 1 | Holding-register-empty interrupt |

## Verification
The frame path is driven with 0x3C, 0xA5, 0x5A, 0xF0, 0x81 and 0x7E. The mix of alternating and grouped bit values shows whether the bit order or the shift count is wrong. A single isolated frame and back-to-back pairs are compared to separate the idle-restart path from the continuous-reload path. Two patterns test write timing. Writing twice before any tick shows whether the holding register overwrites or keeps the older byte. Writing in the same cycle as a transfer tick tests the set-over-clear priority of the interrupt and whether the hold register keeps the new byte.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned FRAME_LEN = BYTE_W + 2;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam int unsigned LAST_IDX  = FRAME_LEN - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
    import ser_tx_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_en_i,
    input  byte_t wr_data_i,
    input  logic  take_i,
    output logic  full_o,
    output byte_t data_o
);
    typedef struct packed {
        logic  full;
        byte_t data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.full = 1'b0;
        end
        if (wr_en_i) begin
            st_d.full = 1'b1;
            st_d.data = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;

    // R9: the latest write is what the register holds
    assert_last_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (st_q.full && st_q.data == $past(wr_data_i)));
endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
    import ser_tx_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  tick_i,
    input  logic  hold_full_i,
    input  byte_t hold_data_i,
    output logic  take_o,
    output logic  txd_o
);
    typedef struct packed {
        logic  busy;
        idx_t  idx;
        byte_t shreg;
        logic  txd;
    } shift_t;

    shift_t st_d, st_q;
    logic   frame_end;

    assign frame_end = !st_q.busy || (st_q.idx == idx_t'(LAST_IDX));

    always_comb begin
        st_d   = st_q;
        take_o = 1'b0;
        if (tick_i) begin
            if (frame_end) begin
                st_d.idx = '0;
                if (hold_full_i) begin
                    take_o     = 1'b1;
                    st_d.busy  = 1'b1;
                    st_d.shreg = hold_data_i;
                    st_d.txd   = 1'b0;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.txd  = 1'b1;
                end
            end else begin
                st_d.idx = idx_t'(st_q.idx + 1'b1);
                if (st_q.idx == idx_t'(LAST_IDX - 1)) begin
                    st_d.txd = 1'b1;
                end else begin
                    st_d.txd   = st_q.shreg[0];
                    st_d.shreg = st_q.shreg >> 1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, idx: '0, shreg: '0, txd: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o = st_q.txd;

    // R8: line rests high whenever no frame is in flight
    assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.busy |-> st_q.txd);
    // R2: the bit index never leaves the frame
    assert_index_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.idx <= idx_t'(LAST_IDX));
    // R4: the shifter moves only on a tick
    assert_move_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(st_q));
endmodule

// File: rtl/tx_bclk_gen.sv
module tx_bclk_gen #(
    parameter int unsigned HIGH_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic bclk_o
);
    localparam int unsigned CNT_W = $clog2(HIGH_CYC + 1);

    typedef struct packed {
        logic             bclk;
        logic [CNT_W-1:0] cnt;
    } bclk_t;

    bclk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.bclk = 1'b1;
            st_d.cnt  = CNT_W'(HIGH_CYC - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.bclk = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;

    // R3: every tick drives the output clock high on the next edge
    assert_tick_raises_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> st_q.bclk);
endmodule

// File: rtl/tx_irq_ctrl.sv
module tx_irq_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.irq = 1'b1;
        end else if (clr_i) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R6: acknowledge or write clears unless a transfer sets
    assert_irq_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !st_q.irq);
    // R5: a transfer always leaves the request high
    assert_irq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> st_q.irq);
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
    import ser_tx_pkg::*;
#(
    parameter int unsigned HIGH_CYC = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic             bit_tick_i,
    input  logic             irq_ack_i,
    output logic             txd_o,
    output logic             bclk_o,
    output logic             irq_o
);
    logic  hold_full;
    byte_t hold_data;
    logic  take;

    tx_hold_reg i_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .take_i   (take),
        .full_o   (hold_full),
        .data_o   (hold_data)
    );

    tx_frame_shift i_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (bit_tick_i),
        .hold_full_i(hold_full),
        .hold_data_i(hold_data),
        .take_o     (take),
        .txd_o      (txd_o)
    );

    tx_bclk_gen #(.HIGH_CYC(HIGH_CYC)) i_bclk (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(bit_tick_i),
        .bclk_o(bclk_o)
    );

    tx_irq_ctrl i_irq (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (take),
        .clr_i (irq_ack_i || wr_en_i),
        .irq_o (irq_o)
    );

    // R3: data moves only together with a rising output clock
    assert_txd_on_bclk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(txd_o) |-> $rose(bclk_o));
    // R5: a newly raised request coincides with a start bit on the line
    assert_irq_with_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> !txd_o);
endmodule

// File: tb/test_dbuf_serial_tx.sv
`timescale 1ns/1ps
module test_dbuf_serial_tx;
    localparam int unsigned HC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic       ack = 1'b0;
    logic       txd, bclk, irq;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dbuf_serial_tx #(.HIGH_CYC(HC)) i_dbuf_serial_tx (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .bit_tick_i(tick),
        .irq_ack_i (ack),
        .txd_o     (txd),
        .bclk_o    (bclk),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // tick spaced four cycles apart; returns at the negedge after the tick edge
    task automatic do_tick(input logic with_wr = 1'b0, input logic [7:0] b = '0);
        repeat (3) @(negedge clk);
        tick = 1'b1;
        if (with_wr) begin
            wr_en = 1'b1;
            wr_data = b;
        end
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // start bit already on the line: check data bits and stop bit (R2)
    task automatic data_and_stop(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            do_tick();
            chk($sformatf("R2 data bit %0d of %h", i, b), {7'd0, txd}, {7'd0, b[i]});
        end
        do_tick();
        chk("R2 stop bit", {7'd0, txd}, 8'd1);
    endtask

    task automatic t_reset();
        chk("R1 txd at reset", {7'd0, txd}, 8'd1);
        chk("R1 bclk at reset", {7'd0, bclk}, 8'd0);
        chk("R1 irq at reset", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_idle_and_clock();
        for (int k = 0; k < 3; k++) begin
            do_tick();
            chk("R8 idle line high", {7'd0, txd}, 8'd1);
            chk("R3 bclk high after tick", {7'd0, bclk}, 8'd1);
        end
        @(negedge clk);
        chk("R3 bclk held for HIGH_CYC", {7'd0, bclk}, 8'd1);
        @(negedge clk);
        chk("R3 bclk low after HIGH_CYC", {7'd0, bclk}, 8'd0);
        chk("R8 no irq while idle", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_single_frame();
        write_byte(8'h3C);
        repeat (6) @(negedge clk);
        chk("R10 no start without tick", {7'd0, txd}, 8'd1);
        chk("R10 no irq without tick", {7'd0, irq}, 8'd0);
        do_tick();
        chk("R4 start bit on tick", {7'd0, txd}, 8'd0);
        chk("R5 irq on transfer", {7'd0, irq}, 8'd1);
        pulse_ack();
        chk("R6 ack clears irq", {7'd0, irq}, 8'd0);
        data_and_stop(8'h3C);
        do_tick();
        chk("R8 idle after stop", {7'd0, txd}, 8'd1);
        do_tick();
        chk("R8 stays idle", {7'd0, txd}, 8'd1);
        chk("R8 no new irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_back_to_back();
        write_byte(8'hA5);
        do_tick();
        chk("R4 start of first", {7'd0, txd}, 8'd0);
        write_byte(8'h5A);
        chk("R6 write clears irq", {7'd0, irq}, 8'd0);
        data_and_stop(8'hA5);
        do_tick();
        chk("R7 next start with no gap", {7'd0, txd}, 8'd0);
        chk("R5 irq on second transfer", {7'd0, irq}, 8'd1);
        data_and_stop(8'h5A);
        do_tick();
        chk("R8 idle after pair", {7'd0, txd}, 8'd1);
        pulse_ack();
    endtask

    task automatic t_overwrite();
        write_byte(8'h11);
        write_byte(8'hF0);
        do_tick();
        chk("R9 start of replaced byte", {7'd0, txd}, 8'd0);
        data_and_stop(8'hF0);
        do_tick();
        chk("R9 nothing left after overwrite", {7'd0, txd}, 8'd1);
        pulse_ack();
    endtask

    task automatic t_set_wins();
        write_byte(8'h81);
        do_tick(1'b1, 8'h7E);
        chk("R6 set wins over write clear", {7'd0, irq}, 8'd1);
        chk("R4 start with concurrent write", {7'd0, txd}, 8'd0);
        data_and_stop(8'h81);
        do_tick();
        chk("R7 concurrent byte follows", {7'd0, txd}, 8'd0);
        data_and_stop(8'h7E);
        do_tick();
        chk("R8 idle at end", {7'd0, txd}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_and_clock();
        t_single_frame();
        t_back_to_back();
        t_overwrite();
        t_set_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule